// File: doc/BRIEF.md
# Light Sensor Integration Sequencer

This block sequences the integration periods of a charge-balancing light-sensor converter. A digital front end, outside this block, emits one single-cycle count pulse for every charge packet on each of two photodiode channels. The sequencer picks which channel to count, opens and closes each integration window, and accumulates the pulses into a 16-bit result. Alongside each result it captures the length of that window in clock cycles.

A window is timed in one of two ways. In the first, an internal cycle counter closes it after 2^16, 2^12, 2^8 or 2^4 cycles. In the second, the host closes it with a sync strobe, so that a window runs from one strobe to the next. A two-pass difference mode counts channel 1 and then channel 2 and reports their signed difference.

The command fields are level inputs that persist until the host rewrites them. Result and timer are held between conversions and change together with a one-cycle done pulse.

Top module: `lis_seq_top`

## Requirements
- R1: With cfg_ext_timing = 0, the window length is set by cfg_width. Value 3 gives 16 cycles, 2 gives 256, 1 gives 4096 and 0 gives 65536. A window begins the cycle after the block becomes active, and each new window follows the previous one with no gap.
- R2: cfg_mode selects the source. 0 counts ch1 and 1 counts ch2. Value 2 runs one window on ch1 and then one on ch2, and raises done only after the second window.
- R3: In modes 0 and 1 the result is the unsigned pulse count, saturating at 0xFFFF. In mode 2 the result is ch1 count minus ch2 count, clamped to the range -16384..16383 and written as a 16-bit two's complement value, so bits 15 and 14 are equal.
- R4: With cfg_ext_timing = 1, the first sync strobe after activation opens a window. Each later strobe closes the current window and opens the next. Pulses are counted from the cycle after the opening strobe up to and including the closing strobe's cycle.
- R5: The timer output is the number of cycles in the window just closed, saturated to 0xFFFF. In mode 2 it is the length of the second window.
- R6: While cfg_enable = 0 or cfg_pdown = 1, no conversion runs, done stays low and result and timer hold. Resuming starts a fresh window.
- R7: cfg_mode = 3 keeps the block idle. No done pulse occurs and the outputs hold.
- R8: Result and timer change only in the cycle where done is high. done lasts one cycle per conversion.
- R9: In externally timed mode the cycle counter saturates at 0xFFFF instead of wrapping.
- R10: Any change of cfg_ext_timing, cfg_mode or cfg_width while active abandons the current window. Counting restarts from zero, and pulses seen before the change are lost.
- R11: The sync strobe has no effect while cfg_ext_timing = 0.
- R12: After reset, result and timer are 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Converter core enable |
| cfg_pdown | input | 1 | Power-down request |
| cfg_ext_timing | input | 1 | 1 = host-timed windows |
| cfg_mode | input | 2 | Source select: 0 ch1, 1 ch2, 2 difference, 3 idle |
| cfg_width | input | 2 | Internal window length select |
| sync_strobe | input | 1 | Host sync strobe, one cycle |
| pulse_ch1 | input | 1 | Charge packet pulse, channel 1 |
| pulse_ch2 | input | 1 | Charge packet pulse, channel 2 |
| result | output | 16 | Latest conversion result |
| timer | output | 16 | Cycle length of the latest window |
| done | output | 1 | One-cycle conversion-complete pulse |

## Verification
The bench targets several corner cases, each tied to a specific failure.
- A full 65536-cycle window with a pulse on every cycle. A design that lets the pulse count or the timer wrap would report a small value instead of 0xFFFF.
- Difference runs where one channel far outweighs the other. These expose a missing clamp or a wrong sign extension.
- Pulses driven before a configuration change. A design that fails to abort would add them to the result or finish early.
- Host-timed windows of a single cycle, and windows longer than 0xFFFF cycles. These catch off-by-one window edges and a wrapping counter.
- Sync noise in internal mode, and activity while disabled, powered down or in the idle mode. These show whether the block keeps the inputs it must ignore out of the result and out of done.

// File: rtl/lis_pkg.sv
package lis_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SRC_CH1  = 2'd0,
    SRC_CH2  = 2'd1,
    SRC_DIFF = 2'd2,
    SRC_IDLE = 2'd3
  } src_e;

  // Internal window length in cycles: 2^(16 - 4*width)
  function automatic logic [16:0] win_cycles(input logic [1:0] w);
    logic [4:0] sh;
    sh = 5'd16 - {1'b0, w, 2'b00};
    return 17'd1 << sh;
  endfunction

  // Clamp a 17-bit count to 16 bits
  function automatic logic [15:0] sat16(input logic [16:0] v);
    return v[16] ? 16'hFFFF : v[15:0];
  endfunction

  // Signed 15-bit clamped difference, sign-extended to 16 bits
  function automatic logic [15:0] diff15(input logic [15:0] a, input logic [15:0] b);
    logic signed [17:0] d;
    d = $signed({2'b00, a}) - $signed({2'b00, b});
    if (d > 18'sd16383)       return 16'h3FFF;
    else if (d < -18'sd16384) return 16'hC000;
    else                      return d[15:0];
  endfunction

endpackage

// File: rtl/lis_cycle_timer.sv
module lis_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  assign at_max = (cnt == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (inc && !at_max)  cnt <= cnt + 1'b1;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && inc && !clr) |=> at_max);                            // R9
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));                                           // R10

endmodule

// File: rtl/lis_pulse_acc.sv
module lis_pulse_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic         pulse,
  output logic [W-1:0] total
);

  logic [W-1:0] acc;
  logic         full;

  assign full  = (acc == {W{1'b1}});
  assign total = (full || !pulse) ? acc : acc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (add)   acc <= total;
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);                                       // R3

endmodule

// File: rtl/lis_capture.sv
module lis_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] res_in,
  input  logic [W-1:0] tim_in,
  output logic [W-1:0] result,
  output logic [W-1:0] timer,
  output logic         done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      timer  <= '0;
      done   <= 1'b0;
    end else begin
      done <= cap;
      if (cap) begin
        result <= res_in;
        timer  <= tim_in;
      end
    end
  end

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(result) && $stable(timer) && !done));         // R8

endmodule

// File: rtl/lis_seq_top.sv
module lis_seq_top
  import lis_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_enable,
  input  logic         cfg_pdown,
  input  logic         cfg_ext_timing,
  input  logic [1:0]   cfg_mode,
  input  logic [1:0]   cfg_width,
  input  logic         sync_strobe,
  input  logic         pulse_ch1,
  input  logic         pulse_ch2,
  output logic [W-1:0] result,
  output logic [W-1:0] timer,
  output logic         done
);

  localparam int CFG_W = 5;

  src_e         src;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic         running_q, armed_q, pass_q;
  logic [W-1:0] first_q;
  logic         active, restart, start_ext, win_open, win_end, capture;
  logic         tick_end, pulse_sel, cnt_clr, cyc_max;
  logic [W-1:0] cyc_cnt, pass_total, cap_val, tim_val;
  logic [16:0]  win_len;

  assign src     = src_e'(cfg_mode);
  assign cfg_now = {cfg_ext_timing, cfg_mode, cfg_width};
  assign active  = cfg_enable && !cfg_pdown && (src != SRC_IDLE);
  assign restart = active && (!running_q || (cfg_now != cfg_q));

  assign start_ext = active && !restart && cfg_ext_timing && sync_strobe && !armed_q;
  assign win_open  = active && !restart && (!cfg_ext_timing || armed_q);

  assign win_len  = win_cycles(cfg_width) - 17'd1;
  assign tick_end = cfg_ext_timing ? sync_strobe : (cyc_cnt == win_len[W-1:0]);
  assign win_end  = win_open && tick_end;
  assign cnt_clr  = !active || restart || start_ext || win_end;

  always_comb begin
    case (src)
      SRC_CH1:  pulse_sel = pulse_ch1;
      SRC_CH2:  pulse_sel = pulse_ch2;
      SRC_DIFF: pulse_sel = pass_q ? pulse_ch2 : pulse_ch1;
      default:  pulse_sel = 1'b0;
    endcase
  end

  lis_cycle_timer #(.W(W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (win_open),
    .cnt    (cyc_cnt),
    .at_max (cyc_max)
  );

  lis_pulse_acc #(.W(W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .add   (win_open),
    .pulse (pulse_sel),
    .total (pass_total)
  );

  assign capture = win_end && ((src != SRC_DIFF) || pass_q);
  assign cap_val = (src == SRC_DIFF) ? diff15(first_q, pass_total) : pass_total;
  assign tim_val = cyc_max ? {W{1'b1}} : cyc_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cfg_q     <= '0;
      armed_q   <= 1'b0;
      pass_q    <= 1'b0;
      first_q   <= '0;
    end else begin
      running_q <= active;
      cfg_q     <= cfg_now;
      if (!active || restart)   armed_q <= 1'b0;
      else if (start_ext)       armed_q <= 1'b1;
      if (!active || restart)   pass_q <= 1'b0;
      else if (win_end && src == SRC_DIFF) pass_q <= !pass_q;
      if (win_end && !pass_q && src == SRC_DIFF) first_q <= pass_total;
    end
  end

  lis_capture #(.W(W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (capture),
    .res_in (cap_val),
    .tim_in (tim_val),
    .result (result),
    .timer  (timer),
    .done   (done)
  );

  AST_INT_TIMER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cfg_ext_timing)) |-> (timer == sat16(win_cycles($past(cfg_width))))); // R1
  AST_FIRST_PASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !pass_q && src == SRC_DIFF) |=> !done);             // R2
  AST_DIFF_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cfg_mode) == 2'd2) |-> (result[15] == result[14])); // R3
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable || cfg_pdown) |=> !done);                          // R6
  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd3) |=> !done);                                  // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cyc_cnt == '0 && !done));                          // R10

endmodule

// File: tb/tb_lis_seq_top.sv
module tb_lis_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_pdown = 1'b0, cfg_ext_timing = 1'b0;
  logic [1:0]  cfg_mode = 2'd0, cfg_width = 2'd3;
  logic        sync_strobe = 1'b0, pulse_ch1 = 1'b0, pulse_ch2 = 1'b0;
  logic [15:0] result, timer;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lis_seq_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_pdown(cfg_pdown),
    .cfg_ext_timing(cfg_ext_timing), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .sync_strobe(sync_strobe), .pulse_ch1(pulse_ch1), .pulse_ch2(pulse_ch2),
    .result(result), .timer(timer), .done(done)
  );

  function automatic int ref_len(input logic [1:0] w);
    case (w)
      2'd3:    return 16;
      2'd2:    return 256;
      2'd1:    return 4096;
      default: return 65536;
    endcase
  endfunction

  function automatic int ref_clip(input int n);
    return (n > 65535) ? 65535 : n;
  endfunction

  function automatic int ref_diff(input int a, input int b);
    int d;
    d = a - b;
    if (d > 16383)  d = 16383;
    if (d < -16384) d = -16384;
    return d & 32'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    cfg_enable = 1'b0; sync_strobe = 1'b0; pulse_ch1 = 1'b0; pulse_ch2 = 1'b0;
  endtask

  // One conversion: windows of internal length or host gap
  task automatic run_conv(input bit ext, input logic [1:0] mode, input logic [1:0] width,
                          input int gap, input int pct1, input int pct2,
                          input bit sync_noise, input string tag);
    int len, npass, cnt_a, cnt_b, stray, exp_res;
    bit p1, p2;
    len   = ext ? gap : ref_len(width);
    npass = (mode == 2'd2) ? 2 : 1;
    cnt_a = 0; cnt_b = 0; stray = 0;
    @(negedge clk);
    cfg_ext_timing = ext; cfg_mode = mode; cfg_width = width;
    cfg_enable = 1'b1; cfg_pdown = 1'b0;
    pulse_ch1 = 1'b0; pulse_ch2 = 1'b0; sync_strobe = 1'b0;
    if (ext) begin
      @(negedge clk);
      sync_strobe = 1'b1;
    end
    for (int p = 0; p < npass; p++) begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (done) stray++;
        p1 = (($urandom % 100) < pct1);
        p2 = (($urandom % 100) < pct2);
        pulse_ch1 = p1; pulse_ch2 = p2;
        if (ext) sync_strobe = (i == len - 1);
        else     sync_strobe = sync_noise && (($urandom % 3) == 0);
        if (p == 0) cnt_a += (mode == 2'd1) ? int'(p2) : int'(p1);
        else        cnt_b += int'(p2);
      end
    end
    @(negedge clk);
    pulse_ch1 = 1'b0; pulse_ch2 = 1'b0; sync_strobe = 1'b0;
    exp_res = (mode == 2'd2) ? ref_diff(cnt_a, cnt_b) : ref_clip(cnt_a);
    chk(stray == 0, {tag, " R8 R2 no early done"}, stray, 0);
    chk(done == 1'b1, {tag, " R8 done pulse"}, int'(done), 1);
    chk(int'(result) == exp_res, {tag, " R3 result"}, int'(result), exp_res);
    chk(int'(timer) == ref_clip(len), {tag, " R5 timer"}, int'(timer), ref_clip(len));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, int'(done), 0);
  endtask

  // Stimulus that must not produce a conversion nor change outputs
  task automatic quiet_phase(input bit en, input bit pd, input logic [1:0] mode, input string tag);
    logic [15:0] r0, t0;
    int seen;
    r0 = result; t0 = timer; seen = 0;
    @(negedge clk);
    cfg_enable = en; cfg_pdown = pd; cfg_mode = mode; cfg_ext_timing = 1'b0; cfg_width = 2'd3;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) seen++;
      pulse_ch1 = 1'b1; pulse_ch2 = 1'b0; sync_strobe = i[0];
    end
    @(negedge clk);
    if (done) seen++;
    chk(seen == 0, {tag, " no done"}, seen, 0);
    chk(result == r0 && timer == t0, {tag, " outputs hold"}, int'(result), int'(r0));
    go_idle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(result == 16'd0 && timer == 16'd0, "R12 reset outputs", int'(result), 0);
    chk(done == 1'b0, "R12 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 16'd0 && done == 1'b0, "R12 after release", int'(result), 0);

    // R1 window lengths, R2 channel choice
    run_conv(1'b0, 2'd0, 2'd3, 0, 60, 20, 1'b0, "R1 w3 ch1"); go_idle();
    run_conv(1'b0, 2'd1, 2'd2, 0, 20, 70, 1'b0, "R1 w2 ch2"); go_idle();
    run_conv(1'b0, 2'd0, 2'd1, 0, 10, 90, 1'b0, "R1 w1 ch1"); go_idle();
    // R1 R3 R5 full window, count and timer saturate
    run_conv(1'b0, 2'd0, 2'd0, 0, 100, 0, 1'b0, "R1 w0 sat"); go_idle();

    // R2 R3 difference with clamping both ways
    run_conv(1'b0, 2'd2, 2'd2, 0, 90, 10, 1'b0, "R2 diff pos"); go_idle();
    run_conv(1'b0, 2'd2, 2'd3, 0, 0, 100, 1'b0, "R2 diff neg"); go_idle();
    run_conv(1'b1, 2'd2, 2'd0, 20000, 100, 0, 1'b0, "R3 diff clamp hi"); go_idle();

    // R4 host timed, shortest window, R9 long window
    run_conv(1'b1, 2'd0, 2'd3, 1, 100, 0, 1'b0, "R4 gap1"); go_idle();
    run_conv(1'b1, 2'd1, 2'd3, 37, 30, 60, 1'b0, "R4 gap37"); go_idle();
    run_conv(1'b1, 2'd0, 2'd3, 66000, 1, 0, 1'b0, "R9 ext sat"); go_idle();

    // R11 sync noise in internal mode
    run_conv(1'b0, 2'd0, 2'd2, 0, 50, 50, 1'b1, "R11 sync ignored"); go_idle();

    // R10 abort on width change: pulses before change are dropped
    @(negedge clk);
    cfg_ext_timing = 1'b0; cfg_mode = 2'd0; cfg_width = 2'd3; cfg_enable = 1'b1; cfg_pdown = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      pulse_ch1 = 1'b1;
    end
    run_conv(1'b0, 2'd0, 2'd2, 0, 5, 5, 1'b0, "R10 abort width"); 
    // R10 abort on mode change mid-window
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      pulse_ch1 = 1'b1; pulse_ch2 = 1'b1;
    end
    run_conv(1'b0, 2'd1, 2'd2, 0, 0, 30, 1'b0, "R10 abort mode"); go_idle();

    // R6 R7 quiet conditions
    quiet_phase(1'b0, 1'b0, 2'd0, "R6 disabled");
    quiet_phase(1'b1, 1'b1, 2'd0, "R6 powerdown");
    quiet_phase(1'b1, 1'b0, 2'd3, "R7 idle mode");
    // R6 resume restarts cleanly
    run_conv(1'b0, 2'd0, 2'd3, 0, 50, 0, 1'b0, "R6 resume"); go_idle();

    // Random mix
    for (int k = 0; k < 10; k++) begin
      bit ext;
      logic [1:0] m, w;
      ext = $urandom % 2;
      m   = 2'($urandom % 3);
      w   = 2'(2 + ($urandom % 2));
      run_conv(ext, m, w, 1 + int'($urandom % 40), int'($urandom % 101), int'($urandom % 101),
               1'b1, "R4 R2 random");
      go_idle();
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule